// File: doc/BRIEF.md
# Linear Page Table Walker

This block resolves a translation miss by reading one entry of a single-level page table held in memory. A miss is presented as a virtual address plus the kind of access that was attempted (read, write or execute). The walker takes the virtual page number out of the address and adds it, scaled to the entry size, to a table base that software loads. It then issues one read for that entry and waits for the data. Finally it judges the entry and ends the walk with a one-cycle completion.

The judgement is made in a fixed order. An entry whose valid bit is clear ends in a segmentation fault. A valid entry that does not grant the requested access ends in a protection fault. Only an entry that passes both checks produces a fill for the translation buffer, which carries the page number, the frame number and the permission bits, so that the faulting access can be replayed. The table base is captured when a miss is accepted, so software may rewrite it at any time without disturbing a walk already in progress.

Entry layout: bit 0 is the valid flag. Bit 1 grants read, bit 2 grants write and bit 3 grants execute. Bits 12 and up hold the frame number.

Top module: `page_walker`

## Requirements
- R1: The read address equals the table base plus the virtual page number times 4. The virtual page number is the virtual address shifted right by OFFS_W bits.
- R2: The read request stays asserted, with a stable address, until it is accepted. Exactly one read is accepted per walk.
- R3: The table base is sampled when the miss is accepted. A change of `ptBase` during a walk does not alter that walk's read address.
- R4: When the fetched entry has bit 0 clear, `done` comes with `fault` = 01 and `fillValid` stays low.
- R5: Access codes are 00 read, 01 write and 10 execute, tested against entry bits 1, 2 and 3 in that order. Code 11 is never granted. A valid entry that does not grant the requested access gives `done` with `fault` = 10 and no fill.
- R6: The valid check comes first. An invalid entry reports 01 whatever its permission bits are.
- R7: On success, `done` and `fillValid` pulse together with `fault` = 00. `fillVpn` holds the page number, `fillPfn` holds entry bits [12+PFN_W-1:12] and `fillPerm` holds entry bits [3:1].
- R8: `done` lasts exactly one cycle. It is asserted in the second cycle after the cycle in which the response is accepted.
- R9: A miss is accepted only while `busy` is low. A miss presented during a walk is ignored and starts no read.
- R10: After reset `busy`, `memReqValid`, `done` and `fillValid` are low and `fault` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ptBase | input | ADDR_W | Page table base address, software loaded |
| missValid | input | 1 | Translation miss presented |
| missVa | input | OFFS_W+VPN_W | Virtual address of the miss |
| missAcc | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| busy | output | 1 | Walk in progress |
| memReqValid | output | 1 | Entry read request |
| memReqAddr | output | ADDR_W | Entry byte address |
| memReqReady | input | 1 | Read request accepted |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | PTE_W | Fetched page table entry |
| fillValid | output | 1 | Insert translation into the TLB |
| fillVpn | output | VPN_W | Virtual page number to insert |
| fillPfn | output | PFN_W | Frame number to insert |
| fillPerm | output | 3 | Execute, write and read grants |
| done | output | 1 | Walk finished (one cycle) |
| fault | output | 2 | 00 none, 01 segmentation, 10 protection |

## Verification
The assertions check, on every cycle, the following rules:
- a read request holds with a stable address until it is accepted, and is not repeated after acceptance;
- `done` is a single-cycle pulse, arriving two cycles after the response is taken;
- a fill never coincides with a fault, and neither appears without `done`.

Only the bench scenarios can show the rest:
- that the address arithmetic is right;
- that the fault classes come out in the stated order for each permission pattern;
- that a base rewritten mid-walk is ignored;
- that a second miss raised during a walk starts nothing.

// File: rtl/pwalk_pkg.sv
package pwalk_pkg;

  localparam int ENTRY_SHIFT = 2;   // 4-byte entries
  localparam int PFN_LSB     = 12;
  localparam int BIT_VALID   = 0;
  localparam int BIT_READ    = 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_WAIT, ST_CHECK, ST_FILL, ST_FAULT
  } walkState_t;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_SEG  = 2'b01,
    FLT_PROT = 2'b10
  } faultCode_t;

  typedef struct packed {
    logic latchMiss;
    logic capPte;
  } walkStrb_t;

  // perm is {exec, write, read}; access code 11 is never granted
  function automatic logic accessAllowed(input logic [2:0] perm, input logic [1:0] acc);
    case (acc)
      2'b00:   return perm[0];
      2'b01:   return perm[1];
      2'b10:   return perm[2];
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pwalk_ctrl.sv
module pwalk_ctrl
  import pwalk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       missValid,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  logic       pteValid,
  input  logic       permOk,
  output walkStrb_t  strb,
  output logic       memReqValid,
  output logic       busy,
  output logic       done,
  output logic       fillValid,
  output logic [1:0] fault
);

  walkState_t stateQ, stateN;
  faultCode_t faultQ, faultN;

  always_comb begin
    stateN = stateQ;
    faultN = faultQ;
    unique case (stateQ)
      ST_IDLE:  if (missValid)   stateN = ST_REQ;
      ST_REQ:   if (memReqReady) stateN = ST_WAIT;
      ST_WAIT:  if (memRspValid) stateN = ST_CHECK;
      ST_CHECK: begin
        if (!pteValid) begin
          stateN = ST_FAULT;
          faultN = FLT_SEG;
        end else if (!permOk) begin
          stateN = ST_FAULT;
          faultN = FLT_PROT;
        end else begin
          stateN = ST_FILL;
          faultN = FLT_NONE;
        end
      end
      ST_FILL:  stateN = ST_IDLE;
      ST_FAULT: stateN = ST_IDLE;
      default:  stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      faultQ <= FLT_NONE;
    end else begin
      stateQ <= stateN;
      faultQ <= faultN;
    end
  end

  always_comb begin
    strb.latchMiss = (stateQ == ST_IDLE) && missValid;
    strb.capPte    = (stateQ == ST_WAIT) && memRspValid;
  end

  assign memReqValid = (stateQ == ST_REQ);
  assign busy        = (stateQ != ST_IDLE);
  assign fillValid   = (stateQ == ST_FILL);
  assign done        = (stateQ == ST_FILL) || (stateQ == ST_FAULT);
  assign fault       = (stateQ == ST_FAULT) ? faultQ : FLT_NONE;

endmodule

// File: rtl/pwalk_dpath.sv
module pwalk_dpath
  import pwalk_pkg::*;
#(
  parameter int VPN_W  = 10,
  parameter int OFFS_W = 12,
  parameter int PFN_W  = 16,
  parameter int ADDR_W = 32,
  parameter int PTE_W  = 32,
  localparam int VA_W  = VPN_W + OFFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrb_t         strb,
  input  logic [ADDR_W-1:0] ptBase,
  input  logic [VA_W-1:0]   missVa,
  input  logic [1:0]        missAcc,
  input  logic [PTE_W-1:0]  memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              pteValid,
  output logic              permOk,
  output logic [VPN_W-1:0]  fillVpn,
  output logic [PFN_W-1:0]  fillPfn,
  output logic [2:0]        fillPerm
);

  localparam logic [VA_W-1:0] VPN_MASK = {{VPN_W{1'b1}}, {OFFS_W{1'b0}}};

  logic [VPN_W-1:0]  vpnQ;
  logic [1:0]        accQ;
  logic [ADDR_W-1:0] baseQ;
  logic [PTE_W-1:0]  pteQ;
  logic [VA_W-1:0]   vpnShifted;

  assign vpnShifted = (missVa & VPN_MASK) >> OFFS_W;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnQ  <= '0;
      accQ  <= '0;
      baseQ <= '0;
      pteQ  <= '0;
    end else begin
      if (strb.latchMiss) begin
        vpnQ  <= vpnShifted[VPN_W-1:0];
        accQ  <= missAcc;
        baseQ <= ptBase;
      end
      if (strb.capPte) pteQ <= memRspData;
    end
  end

  assign memReqAddr = baseQ + (ADDR_W'(vpnQ) << ENTRY_SHIFT);
  assign pteValid   = pteQ[BIT_VALID];
  assign fillPerm   = pteQ[BIT_READ +: 3];
  assign permOk     = accessAllowed(fillPerm, accQ);
  assign fillVpn    = vpnQ;
  assign fillPfn    = pteQ[PFN_LSB +: PFN_W];

endmodule

// File: rtl/page_walker.sv
module page_walker
  import pwalk_pkg::*;
#(
  parameter int VPN_W  = 10,
  parameter int OFFS_W = 12,
  parameter int PFN_W  = 16,
  parameter int ADDR_W = 32,
  parameter int PTE_W  = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         ptBase,
  input  logic                      missValid,
  input  logic [OFFS_W+VPN_W-1:0]   missVa,
  input  logic [1:0]                missAcc,
  output logic                      busy,
  output logic                      memReqValid,
  output logic [ADDR_W-1:0]         memReqAddr,
  input  logic                      memReqReady,
  input  logic                      memRspValid,
  input  logic [PTE_W-1:0]          memRspData,
  output logic                      fillValid,
  output logic [VPN_W-1:0]          fillVpn,
  output logic [PFN_W-1:0]          fillPfn,
  output logic [2:0]                fillPerm,
  output logic                      done,
  output logic [1:0]                fault
);

  walkStrb_t strb;
  logic      pteValid;
  logic      permOk;

  pwalk_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .missValid   (missValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .pteValid    (pteValid),
    .permOk      (permOk),
    .strb        (strb),
    .memReqValid (memReqValid),
    .busy        (busy),
    .done        (done),
    .fillValid   (fillValid),
    .fault       (fault)
  );

  pwalk_dpath #(
    .VPN_W (VPN_W), .OFFS_W (OFFS_W), .PFN_W (PFN_W),
    .ADDR_W(ADDR_W), .PTE_W (PTE_W)
  ) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .ptBase     (ptBase),
    .missVa     (missVa),
    .missAcc    (missAcc),
    .memRspData (memRspData),
    .memReqAddr (memReqAddr),
    .pteValid   (pteValid),
    .permOk     (permOk),
    .fillVpn    (fillVpn),
    .fillPfn    (fillPfn),
    .fillPerm   (fillPerm)
  );

endmodule

// File: rtl/page_walker_chk.sv
module page_walker_chk
  import pwalk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              done,
  input logic              fillValid,
  input logic [1:0]        fault,
  input walkStrb_t         strb
);

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  a_r2_single_read: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqReady |=> !memReqValid);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_rsp_to_done: assert property (@(posedge clk) disable iff (!rstN)
    strb.capPte |=> !done ##1 done);

  a_r4_fault_no_fill: assert property (@(posedge clk) disable iff (!rstN)
    (fault != 2'b00) |-> done && !fillValid);

  a_r7_fill_clean: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> done && (fault == 2'b00));

endmodule

bind page_walker page_walker_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr),
  .done        (done),
  .fillValid   (fillValid),
  .fault       (fault),
  .strb        (strb)
);

// File: tb/test_page_walker.sv
module test_page_walker;

  localparam int VPN_W = 10, OFFS_W = 12, PFN_W = 16, ADDR_W = 32, PTE_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] ptBase = '0;
  logic missValid = 1'b0;
  logic [VPN_W+OFFS_W-1:0] missVa = '0;
  logic [1:0] missAcc = '0;
  logic busy, memReqValid, fillValid, done;
  logic [ADDR_W-1:0] memReqAddr;
  logic memReqReady = 1'b0;
  logic memRspValid = 1'b0;
  logic [PTE_W-1:0] memRspData = '0;
  logic [VPN_W-1:0] fillVpn;
  logic [PFN_W-1:0] fillPfn;
  logic [2:0] fillPerm;
  logic [1:0] fault;

  int nChecks = 0;
  int nFails = 0;
  int reqCount = 0;
  int doneCount = 0;

  always #4 clk = ~clk;   // 125 MHz

  page_walker i_page_walker (
    .clk(clk), .rstN(rstN), .ptBase(ptBase), .missValid(missValid),
    .missVa(missVa), .missAcc(missAcc), .busy(busy),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .memRspData(memRspData), .fillValid(fillValid), .fillVpn(fillVpn),
    .fillPfn(fillPfn), .fillPerm(fillPerm), .done(done), .fault(fault)
  );

  // every-clock model: accepted reads and completions are counted
  // independently and compared after each walk
  always @(posedge clk) begin
    if (rstN && memReqValid && memReqReady) reqCount++;
    if (rstN && done) doneCount++;
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkPte(input bit v, input bit r, input bit w,
                                        input bit x, input logic [15:0] pfn);
    return {4'h0, pfn, 8'h00, x, w, r, v};
  endfunction

  // One walk, sampled at negedges.
  // expFault: 0 none, 1 seg, 2 prot.
  task automatic walk(input logic [21:0] va, input logic [1:0] acc,
                      input logic [31:0] pte, input int rdyDly,
                      input int rspDly, input bit pokeBase,
                      input bit lateMiss, input logic [1:0] expFault,
                      input string req);
    logic [31:0] expAddr;
    logic [9:0]  vpn;
    int reqStart;
    int doneStart;
    vpn = va[21:12];
    expAddr = ptBase + {20'd0, vpn, 2'b00};
    reqStart = reqCount;
    doneStart = doneCount;

    @(negedge clk);
    missValid = 1'b1; missVa = va; missAcc = acc;
    @(negedge clk);
    missValid = 1'b0;
    if (pokeBase) ptBase = ptBase ^ 32'h0F0F_0000;
    check("R1", "address", memReqAddr, expAddr);
    check("R2", "request", memReqValid, 1'b1);
    check("R9", "busy", busy, 1'b1);

    for (int i = 0; i < rdyDly; i++) begin
      @(negedge clk);
      check("R2", "request held", {memReqValid, memReqAddr}, {1'b1, expAddr});
    end
    memReqReady = 1'b1;
    @(negedge clk);
    memReqReady = 1'b0;
    check("R2", "request dropped", memReqValid, 1'b0);
    if (lateMiss) begin
      missValid = 1'b1; missVa = va ^ 22'h2A5000; missAcc = 2'b00;
    end

    for (int i = 0; i < rspDly; i++) begin
      @(negedge clk);
      check("R9", "no read while busy", memReqValid, 1'b0);
    end
    missValid = 1'b0;
    memRspValid = 1'b1; memRspData = pte;
    @(negedge clk);
    memRspValid = 1'b0; memRspData = '0;
    check("R8", "no early done", done, 1'b0);
    @(negedge clk);
    check(req, "done", done, 1'b1);
    check(req, "fault", fault, expFault);
    check(req, "fillValid", fillValid, expFault == 2'b00);
    if (expFault == 2'b00) begin
      check("R7", "fillVpn", fillVpn, vpn);
      check("R7", "fillPfn", fillPfn, pte[27:12]);
      check("R7", "fillPerm", fillPerm, pte[3:1]);
    end
    @(negedge clk);
    check("R8", "done pulse", {done, fault}, 3'b000);
    check("R9", "idle after walk", {busy, memReqValid}, 2'b00);
    check("R2", "one read per walk", reqCount - reqStart, 1);
    check("R8", "one done per walk", doneCount - doneStart, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "reset outputs", {busy, memReqValid, done, fillValid, fault}, 6'b0);
    rstN = 1'b1;
    ptBase = 32'h0000_1000;
    @(negedge clk);
    check("R10", "idle after reset", {busy, memReqValid, done, fillValid, fault}, 6'b0);

    // R7: read of a readable page
    walk(22'h005123, 2'b00, mkPte(1, 1, 0, 0, 16'h00AB), 0, 0, 0, 0, 2'b00, "R7");
    // R5: write to a read-only page
    walk(22'h00A000, 2'b01, mkPte(1, 1, 0, 0, 16'h0011), 1, 2, 0, 0, 2'b10, "R5");
    // R4: invalid entry with full permissions
    walk(22'h011FFF, 2'b00, mkPte(0, 1, 1, 1, 16'h0022), 0, 1, 0, 0, 2'b01, "R4");
    // R6: invalid and no permission, still segmentation
    walk(22'h012000, 2'b01, mkPte(0, 0, 0, 0, 16'h0033), 0, 0, 0, 0, 2'b01, "R6");
    // R7: execute with slow handshake
    walk(22'h0FF456, 2'b10, mkPte(1, 1, 1, 1, 16'hBEEF), 3, 4, 0, 0, 2'b00, "R7");
    // R5: execute refused on rw page
    walk(22'h020000, 2'b10, mkPte(1, 1, 1, 0, 16'h0044), 0, 0, 0, 0, 2'b10, "R5");
    // R5: access code 11 never granted
    walk(22'h030000, 2'b11, mkPte(1, 1, 1, 1, 16'h0055), 0, 0, 0, 0, 2'b10, "R5");
    // R3: base rewritten mid-walk; walk uses sampled base
    walk(22'h040000, 2'b01, mkPte(1, 0, 1, 0, 16'h0066), 2, 1, 1, 0, 2'b00, "R3");
    // R1: next walk sees the new base
    walk(22'h041000, 2'b00, mkPte(1, 1, 0, 0, 16'h0077), 0, 0, 0, 0, 2'b00, "R1");
    // R9: miss raised during a walk is ignored
    walk(22'h050000, 2'b00, mkPte(1, 1, 0, 0, 16'h0088), 0, 3, 0, 1, 2'b00, "R9");
    // R1: top page number with high base
    ptBase = 32'hFFFF_0000;
    walk(22'h3FFFFF, 2'b01, mkPte(1, 0, 1, 0, 16'hFFFF), 0, 0, 0, 0, 2'b00, "R1");

    repeat (3) @(negedge clk);
    check("R9", "no stray walk", {busy, memReqValid}, 2'b00);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule